// File: doc/BRIEF.md
# Calendar Clock with Alarm Match

This block keeps wall-clock time as packed calendar fields (second, minute, hour, weekday, day of month, month) plus a four-digit BCD year. It advances once per second. A prescaler divides the 32768 Hz input clock to make that one-second step. Software writes load registers to set the time and the year. It reads the running values back from separate data registers.

A second pair of registers holds an alarm time and an alarm year. On each second step, the new calendar value is compared with the alarm pair. When every field matches, a raw alarm flag is set. The flag is ANDed with a mask bit to drive the interrupt line, and it stays set until software writes a one to the clear register.

The prescaler length is a parameter, `PRESCALE`, with a default of 32768. A short value lets a test reach calendar boundaries quickly.

Top module: `calendar_clock`

## Requirements
- R1: Register addresses on `wrAddr`/`rdAddr`:
  - 0: time, read only.
  - 1: time load, write only.
  - 2: year, read only.
  - 3: year load, write only.
  - 4: alarm time, read/write.
  - 5: alarm year, read/write.
  - 6: mask (bit 0), read/write.
  - 7: raw status (bit 0), read only.
  - 8: masked status (bit 0), read only.
  - 9: clear, write only.
  - Unlisted and write-only addresses read as 0.
- R1 (continued): After reset the time word is 1 January, weekday 1, 00:00:00, the year is 0x2000, and the raw status, masked status and `irq` are 0.
- R2: Time word field positions are second [5:0], minute [11:6], hour [16:12], weekday [19:17], day of month [24:20] and month [28:25]. Seconds and minutes wrap 59→0 with a carry into the next field, and hours wrap 23→0 with a carry.
- R3: Weekday runs 1..7 (1 = Sunday), advances by one on every day rollover, and wraps from 7 to 1.
- R4: Day of month returns to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, and 31 days for the others except February. After month 12, the month returns to 1.
- R5: February has 29 days when the year is a Gregorian leap year, and 28 days otherwise:
  - When the low BCD byte is nonzero, the year is a leap year if that byte is divisible by 4.
  - When the low byte is 00, the year is a leap year if the century byte is divisible by 4.
- R6: The year register holds the low two decimal digits in BCD in [7:0] and the century in BCD in [15:8]. It increments on the month 12 → 1 rollover with decimal carries, so 0x1999 → 0x2000 and 0x2099 → 0x2100.
- R7: A write to either load register replaces that value on the next clock edge and restarts the prescaler. The next one-second step comes exactly `PRESCALE` cycles after the write edge.
- R8: The raw flag (status bit 0) is set only on a one-second step whose new time and year both equal the alarm pair. A mismatch in the year alone, or loading a value equal to the alarm, does not set it.
- R9: The raw flag stays set until it is cleared. It is not set again unless another one-second step lands on the alarm value.
- R10: The masked status bit 0 and `irq` both equal the raw flag ANDed with mask bit 0.
- R11: Writing data with bit 0 = 1 to the clear register clears the raw flag. Writing bit 0 = 0 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz clock |
| rstN | input | 1 | asynchronous active-low reset |
| wrEn | input | 1 | register write strobe |
| wrAddr | input | 4 | write address |
| wrData | input | 32 | write data |
| rdAddr | input | 4 | read address |
| rdData | output | 32 | read data, combinational from `rdAddr` |
| irq | output | 1 | alarm interrupt, raw flag AND mask |

## Verification
The cases that are hardest to reach from the ports are the rare rollovers: year end, leap and non-leap February, century years, and the 99 → 00 BCD carry. Each normally takes months or years of one-second steps. The bench shortens the prescaler through its parameter. It then loads the calendar a second or two before each boundary, lets the needed number of steps pass, and compares the fields with values worked out from the calendar rules. The alarm is checked the same way: the alarm is placed a couple of seconds ahead of a loaded time, and the bench checks the tick-only evaluation and the sticky flag around it.

// File: rtl/calendar_pkg.sv
package calendar_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int YEAR_W = 16;
  localparam int DIGITS = YEAR_W / 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_TIME_RD  = 4'd0,
    REG_TIME_LD  = 4'd1,
    REG_YEAR_RD  = 4'd2,
    REG_YEAR_LD  = 4'd3,
    REG_ALM_TIME = 4'd4,
    REG_ALM_YEAR = 4'd5,
    REG_MASK     = 4'd6,
    REG_RAW      = 4'd7,
    REG_MASKED   = 4'd8,
    REG_CLEAR    = 4'd9
  } regSel_e;

  // packed time word, field positions are visible to software
  typedef struct packed {
    logic [2:0] pad;
    logic [3:0] month;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] minute;
    logic [5:0] second;
  } calTime_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic ldTime;
    logic ldYear;
    logic wrAlmTime;
    logic wrAlmYear;
    logic wrMask;
    logic clrAlarm;
  } strobes_t;

  function automatic logic [YEAR_W-1:0] bcdYearInc(input logic [YEAR_W-1:0] y);
    logic [YEAR_W-1:0] r;
    logic carry;
    r = y;
    carry = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (carry) begin
        if (y[i*4 +: 4] >= 4'd9) begin
          r[i*4 +: 4] = 4'd0;
        end else begin
          r[i*4 +: 4] = y[i*4 +: 4] + 4'd1;
          carry = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic isLeap(input logic [YEAR_W-1:0] y);
    logic [6:0] lo;
    logic [6:0] cen;
    lo  = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    cen = 7'(y[15:12]) * 7'd10 + 7'(y[11:8]);
    if (lo == 7'd0) return (cen[1:0] == 2'd0);
    return (lo[1:0] == 2'd0);
  endfunction

  function automatic logic [4:0] monthDays(input logic [3:0] month, input logic leap);
    case (month)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return leap ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/calendar_ctrl.sv
module calendar_ctrl
  import calendar_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrBit0,
  output strobes_t          strobe
);

  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] preCnt;
  logic anyLoad;
  logic wrapNow;

  assign anyLoad = wrEn && (wrAddr == REG_TIME_LD || wrAddr == REG_YEAR_LD);
  assign wrapNow = (preCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  preCnt <= '0;
    else if (anyLoad || wrapNow) preCnt <= '0;
    else                        preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobe           = '0;
    strobe.tick      = wrapNow && !anyLoad;
    strobe.ldTime    = wrEn && (wrAddr == REG_TIME_LD);
    strobe.ldYear    = wrEn && (wrAddr == REG_YEAR_LD);
    strobe.wrAlmTime = wrEn && (wrAddr == REG_ALM_TIME);
    strobe.wrAlmYear = wrEn && (wrAddr == REG_ALM_YEAR);
    strobe.wrMask    = wrEn && (wrAddr == REG_MASK);
    strobe.clrAlarm  = wrEn && (wrAddr == REG_CLEAR) && wrBit0;
  end

endmodule

// File: rtl/calendar_datapath.sv
module calendar_datapath
  import calendar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              rawFlag,
  output logic [DATA_W-1:0] timeWord
);

  localparam calTime_t TIME_RST = '{pad: 3'd0, month: 4'd1, mday: 5'd1, wday: 3'd1,
                                    hour: 5'd0, minute: 6'd0, second: 6'd0};
  localparam logic [YEAR_W-1:0] YEAR_RST = 16'h2000;

  calTime_t          timeVal, nextTime, almTime, wrTime;
  logic [YEAR_W-1:0] yearVal, nextYear, almYear;
  logic              maskBit;
  logic              leapNow;
  logic              matchNow;

  assign wrTime  = calTime_t'({3'b000, wrData[28:0]});
  assign leapNow = isLeap(yearVal);

  // next calendar value, one second later
  always_comb begin
    nextTime = timeVal;
    nextYear = yearVal;
    if (timeVal.second >= 6'd59) begin
      nextTime.second = 6'd0;
      if (timeVal.minute >= 6'd59) begin
        nextTime.minute = 6'd0;
        if (timeVal.hour >= 5'd23) begin
          nextTime.hour = 5'd0;
          nextTime.wday = (timeVal.wday >= 3'd7 || timeVal.wday == 3'd0) ? 3'd1 : timeVal.wday + 3'd1;
          if (timeVal.mday >= monthDays(timeVal.month, leapNow)) begin
            nextTime.mday = 5'd1;
            if (timeVal.month >= 4'd12) begin
              nextTime.month = 4'd1;
              nextYear = bcdYearInc(yearVal);
            end else begin
              nextTime.month = timeVal.month + 4'd1;
            end
          end else begin
            nextTime.mday = timeVal.mday + 5'd1;
          end
        end else begin
          nextTime.hour = timeVal.hour + 5'd1;
        end
      end else begin
        nextTime.minute = timeVal.minute + 6'd1;
      end
    end else begin
      nextTime.second = timeVal.second + 6'd1;
    end
  end

  assign matchNow = strobe.tick && (nextTime == almTime) && (nextYear == almYear);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeVal <= TIME_RST;
      yearVal <= YEAR_RST;
    end else begin
      if (strobe.ldTime)    timeVal <= wrTime;
      else if (strobe.tick) timeVal <= nextTime;
      if (strobe.ldYear)    yearVal <= wrData[YEAR_W-1:0];
      else if (strobe.tick) yearVal <= nextYear;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almTime <= '0;
      almYear <= '0;
      maskBit <= 1'b0;
      rawFlag <= 1'b0;
    end else begin
      if (strobe.wrAlmTime) almTime <= wrTime;
      if (strobe.wrAlmYear) almYear <= wrData[YEAR_W-1:0];
      if (strobe.wrMask)    maskBit <= wrData[0];
      if (matchNow)             rawFlag <= 1'b1;
      else if (strobe.clrAlarm) rawFlag <= 1'b0;
    end
  end

  assign irq      = rawFlag & maskBit;
  assign timeWord = timeVal;

  always_comb begin
    rdData = '0;
    case (rdAddr)
      REG_TIME_RD:  rdData = timeVal;
      REG_YEAR_RD:  rdData = DATA_W'(yearVal);
      REG_ALM_TIME: rdData = almTime;
      REG_ALM_YEAR: rdData = DATA_W'(almYear);
      REG_MASK:     rdData = DATA_W'(maskBit);
      REG_RAW:      rdData = DATA_W'(rawFlag);
      REG_MASKED:   rdData = DATA_W'(rawFlag & maskBit);
      default:      rdData = '0;
    endcase
  end

endmodule

// File: rtl/calendar_clock.sv
module calendar_clock
  import calendar_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [3:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        irq
);

  strobes_t    strobe;
  logic        tickSeen;
  logic        rawFlag;
  logic [31:0] timeWord;

  calendar_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrBit0 (wrData[0]),
    .strobe (strobe)
  );

  calendar_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .irq      (irq),
    .rawFlag  (rawFlag),
    .timeWord (timeWord)
  );

  assign tickSeen = strobe.tick;

endmodule

// File: rtl/calendar_clock_chk.sv
module calendar_clock_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [3:0]  wrAddr,
  input logic [31:0] wrData,
  input logic [3:0]  rdAddr,
  input logic [31:0] rdData,
  input logic        irq,
  input logic        tick,
  input logic        rawFlag,
  input logic [31:0] timeWord
);

  // R2: a step from second 59 lands on second 0
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tick && timeWord[5:0] == 6'd59) |=> (timeWord[5:0] == 6'd0));

  // R7: without a step or a time load the time word holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !(wrEn && wrAddr == 4'd1)) |=> $stable(timeWord));

  // R8: the raw flag only rises after a one-second step
  a_r8_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawFlag) |-> $past(tick));

  // R10: masked status read agrees with the interrupt line
  a_r10_masked_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 4'd8) |-> (rdData[0] == irq));

  // R11: a clear with bit 0 set drops the flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 4'd9 && wrData[0] && !tick) |=> !rawFlag);

  // R11: a clear with bit 0 low keeps the flag
  a_r11_keep: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 4'd9 && !wrData[0] && rawFlag) |=> rawFlag);

endmodule

bind calendar_clock calendar_clock_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .rdAddr   (rdAddr),
  .rdData   (rdData),
  .irq      (irq),
  .tick     (tickSeen),
  .rawFlag  (rawFlag),
  .timeWord (timeWord)
);

// File: tb/calendar_clock_test.sv
module calendar_clock_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK = 4;
  localparam int NV = 12;
  localparam int NCOL = 16;

  // columns: mon mday wday hr min sec year steps | emon emday ewday ehr emin esec eyear | req
  localparam int VEC [NV][NCOL] = '{
    '{3, 15, 4, 12, 34, 56, 'h2024, 3,  3, 15, 4, 12, 34, 59, 'h2024, 2},   // R2 seconds
    '{3, 15, 4, 10, 59, 58, 'h2024, 2,  3, 15, 4, 11,  0,  0, 'h2024, 2},   // R2 min/hour carry
    '{12, 31, 7, 23, 59, 59, 'h1999, 1, 1,  1, 1,  0,  0,  0, 'h2000, 6},   // R6 R3 year end
    '{2, 28, 4, 23, 59, 59, 'h2024, 1,  2, 29, 5,  0,  0,  0, 'h2024, 5},   // R5 leap
    '{2, 28, 3, 23, 59, 59, 'h2023, 1,  3,  1, 4,  0,  0,  0, 'h2023, 5},   // R5 common
    '{2, 28, 1, 23, 59, 59, 'h2100, 1,  3,  1, 2,  0,  0,  0, 'h2100, 5},   // R5 century not leap
    '{2, 28, 2, 23, 59, 59, 'h2000, 1,  2, 29, 3,  0,  0,  0, 'h2000, 5},   // R5 century leap
    '{4, 30, 3, 23, 59, 59, 'h2024, 1,  5,  1, 4,  0,  0,  0, 'h2024, 4},   // R4 30-day
    '{1, 31, 4, 23, 59, 59, 'h2024, 1,  2,  1, 5,  0,  0,  0, 'h2024, 4},   // R4 31-day
    '{2, 29, 5, 23, 59, 59, 'h2024, 1,  3,  1, 6,  0,  0,  0, 'h2024, 5},   // R5 end of leap Feb
    '{12, 31, 5, 23, 59, 59, 'h2099, 1, 1,  1, 6,  0,  0,  0, 'h2100, 6},   // R6 century carry
    '{6, 30, 7, 23, 59, 59, 'h2024, 1,  7,  1, 1,  0,  0,  0, 'h2024, 3}    // R3 weekday wrap
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calendar_clock #(.PRESCALE(TICK)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  function automatic logic [31:0] pack(int mo, int md, int wd, int h, int mi, int s);
    return (32'(mo) << 25) | (32'(md) << 20) | (32'(wd) << 17) |
           (32'(h) << 12) | (32'(mi) << 6) | 32'(s);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic steps(int n);
    repeat (n * TICK) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); check("R1 reset time", v, pack(1, 1, 1, 0, 0, 0));
    rd(4'd2, v); check("R1 reset year", v, 32'h2000);
    rd(4'd7, v); check("R1 reset raw", v, 32'd0);
    rd(4'd8, v); check("R1 reset masked", v, 32'd0);
    check("R1 reset irq", 32'(irq), 32'd0);
    rd(4'd1, v); check("R1 load reg reads zero", v, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(4'd3, 32'(VEC[i][6]));
      wr(4'd1, pack(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]));
      steps(VEC[i][7]);
      rd(4'd0, v);
      check($sformatf("R%0d row %0d time", VEC[i][15], i), v,
            pack(VEC[i][8], VEC[i][9], VEC[i][10], VEC[i][11], VEC[i][12], VEC[i][13]));
      rd(4'd2, v);
      check($sformatf("R%0d row %0d year", VEC[i][15], i), v, 32'(VEC[i][14]));
    end

    // R7 prescaler restart on load
    t0 = pack(5, 10, 3, 8, 20, 30);
    wr(4'd1, t0);
    repeat (TICK - 1) @(negedge clk);
    rd(4'd0, v); check("R7 no step before PRESCALE", v, t0);
    @(negedge clk);
    rd(4'd0, v); check("R7 step at PRESCALE", v, pack(5, 10, 3, 8, 20, 31));

    // R8 R9 R10 R11 alarm
    wr(4'd6, 32'd0);
    wr(4'd5, 32'h2024);
    wr(4'd4, pack(2, 29, 5, 10, 0, 2));
    wr(4'd3, 32'h2024);
    wr(4'd1, pack(2, 29, 5, 10, 0, 0));
    steps(1);
    rd(4'd7, v); check("R8 no match yet", v, 32'd0);
    steps(1);
    rd(4'd7, v); check("R8 match sets raw", v, 32'd1);
    rd(4'd8, v); check("R10 masked off", v, 32'd0);
    check("R10 irq masked off", 32'(irq), 32'd0);
    wr(4'd6, 32'd1);
    rd(4'd8, v); check("R10 masked on", v, 32'd1);
    check("R10 irq on", 32'(irq), 32'd1);
    wr(4'd9, 32'hFFFF_FFFE);
    rd(4'd7, v); check("R11 clear with bit0 low keeps flag", v, 32'd1);
    wr(4'd9, 32'd1);
    rd(4'd7, v); check("R11 clear drops flag", v, 32'd0);
    check("R11 irq after clear", 32'(irq), 32'd0);
    steps(3);
    rd(4'd7, v); check("R9 no repeat after match passes", v, 32'd0);

    // R8 year mismatch
    wr(4'd5, 32'h2025);
    wr(4'd4, pack(2, 29, 5, 10, 0, 1));
    wr(4'd3, 32'h2024);
    wr(4'd1, pack(2, 29, 5, 10, 0, 0));
    steps(2);
    rd(4'd7, v); check("R8 year mismatch no flag", v, 32'd0);

    // R8 loading the alarm value does not set the flag
    wr(4'd5, 32'h2024);
    wr(4'd4, pack(2, 29, 5, 11, 0, 0));
    wr(4'd1, pack(2, 29, 5, 11, 0, 0));
    rd(4'd7, v); check("R8 load equal to alarm no flag", v, 32'd0);
    steps(1);
    rd(4'd7, v); check("R8 still no flag after step", v, 32'd0);

    finish_run();
  end

endmodule